// File: doc/BRIEF.md
# ADC Lane Test-Pattern Generator

This block sits between the sample path of a four-channel converter and the per-wire serializers. It either passes each channel's converted sample straight through or replaces it with a known test pattern: all zeros, all ones, an alternating toggle word, a user word loaded from two configuration fields, a framing (sync) pattern, or a bit-deskew pattern. The chosen pattern is applied to every channel at the same time. A receiver uses these patterns to check its capture clock phase, find the frame boundary and check that the link works end to end.

Each channel drives one or two serial wires. The block builds the parallel frame for each wire itself. The frame depends on the wire mode (one or two wires per channel), the serialization factor (14 or 16 bits per sample) and the bit order (most significant or least significant bit first). It produces the frame every sample clock and marks it with a frame strobe. The pattern select passes through a small mode state machine. Its states are Pass, Zero, One, ToggleA, ToggleB, Custom, Sync and Deskew. On every clock the machine moves to the state named by the select code. The toggle code is the one exception: it enters ToggleA from any other state and then alternates ToggleA→ToggleB→ToggleA while the code is held. Code 7 is reserved and moves to Zero. Reset puts the machine in Pass.

Frame layout: channel c, wire w occupies bits [(c*2+w)*16 +: 16] of `lane_frame`. Bit 15 is the first bit sent. A wire uses L bits, from bit 15 downward. L is 14 or 16 in 1-wire mode and 7 or 8 in 2-wire mode. The remaining low bits are zero. Pattern codes: 0 pass, 1 zeros, 2 ones, 3 toggle, 4 custom, 5 sync, 6 deskew, 7 reserved (zeros).

Top module: `adc_tpg`

## Requirements
- R1: While reset is asserted, `lane_frame` is all zero and `frame_vld` is low. From the first clock edge after reset is released, `frame_vld` is high on every cycle.
- R2: With code 0, each channel's 14-bit sample is placed in its frame, and a sample change shows up on the first clock edge after it.
- R3: Code 1 and reserved code 7 give all-zero frames. Code 2 sets every used bit of every used wire to one (14 or 16 bits in 1-wire mode).
- R4: With code 3, the 14-bit word is 10101010101010 in the first frame after entry, then 01010101010101, and keeps alternating frame by frame.
- R5: With code 4, the 14-bit word is {cust_hi, cust_lo}, with cust_hi as the upper seven bits.
- R6: With code 5 in 1-wire mode, the wire frame is seven ones then seven zeros at 14x, and eight ones then eight zeros at 16x.
- R7: With code 5 in 2-wire mode, each of the two wires carries 1111000 at 14x and 11110000 at 16x.
- R8: With code 6, the used bits alternate 1,0,1,0… starting with 1 in send order: 14 bits at 14x and 16 bits at 16x.
- R9: At 16x, a 14-bit data word (sample, toggle, custom) is followed by two zero bits to fill the 16-bit frame. At 14x, the two low frame bits are zero.
- R10: In 2-wire mode, wire 0 carries the first half of the word and wire 1 the second half. In 1-wire mode, wire 1 is all zero.
- R11: When `lsb_first` is high, the used bits of each wire frame are sent in reverse order.
- R12: Every pattern other than pass is identical on all four channels.
- R13: A new pattern code reaches the frames two clock edges after it is applied. The frame in between is still the old pattern in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample (frame) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_sel | input | 3 | Pattern code (0 pass … 6 deskew, 7 reserved) |
| cust_hi | input | 7 | Upper seven bits of the custom word |
| cust_lo | input | 7 | Lower seven bits of the custom word |
| two_wire | input | 1 | 1 = two wires per channel, 0 = one wire |
| ser16 | input | 1 | 1 = 16x serialization, 0 = 14x |
| lsb_first | input | 1 | 1 = each wire frame sent LSB first |
| sample_in | input | 56 | Sample data, channel c at [c*14 +: 14] |
| lane_frame | output | 128 | Per-wire parallel frames, layout as above |
| frame_vld | output | 1 | Frame strobe, high on every frame after reset |

## Verification
The pattern code goes through two registers: the mode state, then the output frame. A code change is therefore checked at the second falling edge after it is driven, and the first falling edge is checked to still show the old frame. The sample data, the custom fields and the wire, order and serialization selects are registered only once. The pass-through test changes a sample and checks it at the very next falling edge. The toggle test checks three frames in a row to confirm the alternation starts on the 10… word. Table vectors hold all inputs steady for three edges before the check, so both latencies have passed.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [2:0] {
        S_PASS  = 3'd0,
        S_ZERO  = 3'd1,
        S_ONE   = 3'd2,
        S_TOG_A = 3'd3,
        S_TOG_B = 3'd4,
        S_CUST  = 3'd5,
        S_SYNC  = 3'd6,
        S_DESK  = 3'd7
    } mode_e;

    localparam logic [2:0] SEL_PASS = 3'd0;
    localparam logic [2:0] SEL_ZERO = 3'd1;
    localparam logic [2:0] SEL_ONE  = 3'd2;
    localparam logic [2:0] SEL_TOG  = 3'd3;
    localparam logic [2:0] SEL_CUST = 3'd4;
    localparam logic [2:0] SEL_SYNC = 3'd5;
    localparam logic [2:0] SEL_DESK = 3'd6;
    localparam logic [2:0] SEL_RSVD = 3'd7;

endpackage

// File: rtl/tpg_mode_fsm.sv
module tpg_mode_fsm
    import tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pat_sel,
    output mode_e      mode_q
);

    mode_e mode_d;

    // next state from the select code; toggle alternates while held
    always_comb begin
        mode_d = S_PASS;
        unique case (pat_sel)
            SEL_PASS: mode_d = S_PASS;
            SEL_ZERO: mode_d = S_ZERO;
            SEL_ONE:  mode_d = S_ONE;
            SEL_TOG:  mode_d = (mode_q == S_TOG_A) ? S_TOG_B : S_TOG_A;
            SEL_CUST: mode_d = S_CUST;
            SEL_SYNC: mode_d = S_SYNC;
            SEL_DESK: mode_d = S_DESK;
            SEL_RSVD: mode_d = S_ZERO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= S_PASS;
        else        mode_q <= mode_d;
    end

endmodule

// File: rtl/tpg_word.sv
module tpg_word
    import tpg_pkg::*;
#(
    parameter int WORD_W  = 14,
    parameter int FRAME_W = 16
) (
    input  mode_e               mode,
    input  logic [WORD_W-1:0]   sample,
    input  logic [WORD_W-1:0]   custom,
    input  logic                ser16,
    output logic [FRAME_W-1:0]  word,
    output logic                is_sync
);

    localparam int PAD_W = FRAME_W - WORD_W;

    logic [FRAME_W-1:0] alt;
    logic [FRAME_W-1:0] used_mask;
    logic [WORD_W-1:0]  tog;

    // word is left-justified: bit FRAME_W-1 goes out first
    always_comb begin
        for (int i = 0; i < FRAME_W; i++) begin
            alt[i] = ((FRAME_W - 1 - i) % 2) == 0;
        end
        tog       = alt[FRAME_W-1 -: WORD_W];
        used_mask = ser16 ? '1 : {{WORD_W{1'b1}}, {PAD_W{1'b0}}};
        is_sync   = 1'b0;
        word      = '0;
        unique case (mode)
            S_PASS:  word = {sample, {PAD_W{1'b0}}};
            S_ZERO:  word = '0;
            S_ONE:   word = used_mask;
            S_TOG_A: word = {tog, {PAD_W{1'b0}}};
            S_TOG_B: word = {~tog, {PAD_W{1'b0}}};
            S_CUST:  word = {custom, {PAD_W{1'b0}}};
            S_SYNC:  is_sync = 1'b1;
            S_DESK:  word = alt & used_mask;
        endcase
    end

endmodule

// File: rtl/tpg_wire_fmt.sv
module tpg_wire_fmt #(
    parameter int WORD_W     = 14,
    parameter int FRAME_W    = 16,
    parameter int SYNC2_ONES = 4
) (
    input  logic [FRAME_W-1:0] word,
    input  logic               is_sync,
    input  logic               two_wire,
    input  logic               ser16,
    input  logic               lsb_first,
    output logic [FRAME_W-1:0] wire0,
    output logic [FRAME_W-1:0] wire1
);

    localparam int HALF14 = WORD_W / 2;
    localparam int HALF16 = FRAME_W / 2;

    logic [FRAME_W-1:0] low_half;
    logic [FRAME_W-1:0] raw0;
    logic [FRAME_W-1:0] raw1;
    int                 wlen;
    int                 ones;

    always_comb begin
        if (two_wire) wlen = ser16 ? HALF16 : HALF14;
        else          wlen = ser16 ? FRAME_W : WORD_W;
        ones     = two_wire ? SYNC2_ONES : wlen / 2;
        low_half = word << wlen;
        raw0     = '0;
        raw1     = '0;
        // MSB-first frame per wire
        for (int i = 0; i < FRAME_W; i++) begin
            if (i < wlen) begin
                if (is_sync) begin
                    raw0[FRAME_W-1-i] = (i < ones);
                    raw1[FRAME_W-1-i] = two_wire && (i < ones);
                end else begin
                    raw0[FRAME_W-1-i] = word[FRAME_W-1-i];
                    raw1[FRAME_W-1-i] = two_wire && low_half[FRAME_W-1-i];
                end
            end
        end
        // optional reversal of the used field of each wire
        wire0 = '0;
        wire1 = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            if (i < wlen) begin
                if (lsb_first) begin
                    wire0[FRAME_W-1-i] = raw0[FRAME_W-wlen+i];
                    wire1[FRAME_W-1-i] = raw1[FRAME_W-wlen+i];
                end else begin
                    wire0[FRAME_W-1-i] = raw0[FRAME_W-1-i];
                    wire1[FRAME_W-1-i] = raw1[FRAME_W-1-i];
                end
            end
        end
    end

endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
    import tpg_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int WORD_W  = 14,
    parameter int FRAME_W = 16,
    parameter int LO_W    = WORD_W / 2,
    parameter int HI_W    = WORD_W - LO_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 pat_sel,
    input  logic [HI_W-1:0]            cust_hi,
    input  logic [LO_W-1:0]            cust_lo,
    input  logic                       two_wire,
    input  logic                       ser16,
    input  logic                       lsb_first,
    input  logic [NCH*WORD_W-1:0]      sample_in,
    output logic [NCH*2*FRAME_W-1:0]   lane_frame,
    output logic                       frame_vld
);

    localparam int BUS_W = NCH * 2 * FRAME_W;

    mode_e            mode_q;
    logic [BUS_W-1:0] lane_nxt;

    tpg_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pat_sel (pat_sel),
        .mode_q  (mode_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [FRAME_W-1:0] word;
        logic               is_sync;

        tpg_word #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) u_word (
            .mode    (mode_q),
            .sample  (sample_in[c*WORD_W +: WORD_W]),
            .custom  ({cust_hi, cust_lo}),
            .ser16   (ser16),
            .word    (word),
            .is_sync (is_sync)
        );

        tpg_wire_fmt #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) u_fmt (
            .word      (word),
            .is_sync   (is_sync),
            .two_wire  (two_wire),
            .ser16     (ser16),
            .lsb_first (lsb_first),
            .wire0     (lane_nxt[(2*c)*FRAME_W +: FRAME_W]),
            .wire1     (lane_nxt[(2*c+1)*FRAME_W +: FRAME_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_frame <= '0;
            frame_vld  <= 1'b0;
        end else begin
            lane_frame <= lane_nxt;
            frame_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk
    import tpg_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int FRAME_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               pat_sel,
    input logic                     two_wire,
    input logic                     ser16,
    input mode_e                    mode_q,
    input logic [NCH*2*FRAME_W-1:0] lane_frame,
    input logic                     frame_vld
);

    logic armed;
    logic lanes_equal;
    logic wire1_zero;
    logic low_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        lanes_equal = 1'b1;
        wire1_zero  = 1'b1;
        low_clear   = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            if (lane_frame[c*2*FRAME_W +: 2*FRAME_W] != lane_frame[0 +: 2*FRAME_W])
                lanes_equal = 1'b0;
            if (lane_frame[(2*c+1)*FRAME_W +: FRAME_W] != '0)
                wire1_zero = 1'b0;
            for (int w = 0; w < 2; w++) begin
                if (lane_frame[(2*c+w)*FRAME_W +: 2] != 2'b00)
                    low_clear = 1'b0;
            end
        end
    end

    // R1: strobe present on every frame once out of reset
    p_vld_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> frame_vld);

    // R4: toggle alternates while its code is held
    p_tog_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == S_TOG_A && pat_sel == SEL_TOG) |=> mode_q == S_TOG_B);

    // R13: a code is reflected in the mode one edge later
    p_sel_track_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == SEL_CUST) |=> mode_q == S_CUST);

    // R12: non-pass patterns identical on every channel
    p_lanes_eq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_q) != S_PASS) |-> lanes_equal);

    // R10: second wire idle in 1-wire mode
    p_wire1_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(two_wire)) |-> wire1_zero);

    // R9: 14x frames leave the two final bit slots clear
    p_pad_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(ser16)) |-> low_clear);

endmodule

bind adc_tpg adc_tpg_chk #(.NCH(NCH), .FRAME_W(FRAME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pat_sel    (pat_sel),
    .two_wire   (two_wire),
    .ser16      (ser16),
    .mode_q     (mode_q),
    .lane_frame (lane_frame),
    .frame_vld  (frame_vld)
);

// File: tb/adc_tpg_tb.sv
module adc_tpg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NVEC = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   pat_sel = 3'd0;
    logic [6:0]   cust_hi = 7'd0;
    logic [6:0]   cust_lo = 7'd0;
    logic         two_wire = 1'b0;
    logic         ser16 = 1'b0;
    logic         lsb_first = 1'b0;
    logic [55:0]  sample_in = '0;
    logic [127:0] lane_frame;
    logic         frame_vld;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_tpg u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_sel    (pat_sel),
        .cust_hi    (cust_hi),
        .cust_lo    (cust_lo),
        .two_wire   (two_wire),
        .ser16      (ser16),
        .lsb_first  (lsb_first),
        .sample_in  (sample_in),
        .lane_frame (lane_frame),
        .frame_vld  (frame_vld)
    );

    // vector: {sel, two_wire, ser16, lsb, hi, lo, sample}
    localparam logic [33:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 14'h2A5C},
        {3'd0, 1'b1, 1'b1, 1'b1, 7'h00, 7'h00, 14'h1234},
        {3'd1, 1'b1, 1'b1, 1'b1, 7'h00, 7'h00, 14'h3FFF},
        {3'd2, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd2, 1'b1, 1'b1, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd4, 1'b0, 1'b0, 1'b0, 7'h55, 7'h0F, 14'h0000},
        {3'd4, 1'b1, 1'b0, 1'b0, 7'h55, 7'h0F, 14'h0000},
        {3'd4, 1'b1, 1'b1, 1'b1, 7'h31, 7'h4E, 14'h0000},
        {3'd4, 1'b0, 1'b1, 1'b1, 7'h31, 7'h4E, 14'h0000},
        {3'd5, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd5, 1'b0, 1'b1, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd5, 1'b1, 1'b0, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd5, 1'b1, 1'b1, 1'b1, 7'h00, 7'h00, 14'h0000},
        {3'd5, 1'b0, 1'b0, 1'b1, 7'h00, 7'h00, 14'h0000},
        {3'd6, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd6, 1'b1, 1'b1, 1'b0, 7'h00, 7'h00, 14'h0000},
        {3'd6, 1'b1, 1'b0, 1'b1, 7'h00, 7'h00, 14'h0000},
        {3'd7, 1'b0, 1'b1, 1'b0, 7'h00, 7'h00, 14'h3FFF}
    };

    // independent model: serial stream index per wire, then placed from bit 15 down
    function automatic logic [15:0] mdl_wire(int sel, int w, logic tw, logic s16,
                                             logic lsb, logic [13:0] d);
        int n, wl, ones, k, s;
        logic [15:0] r;
        logic b;
        n = s16 ? 16 : 14;
        wl = tw ? n / 2 : n;
        ones = tw ? 4 : n / 2;
        r = '0;
        if (!tw && w == 1) return r;
        for (int j = 0; j < wl; j++) begin
            k = lsb ? (wl - 1 - j) : j;
            s = (tw && w == 1) ? k + wl : k;
            case (sel)
                1, 7:    b = 1'b0;
                2:       b = 1'b1;
                5:       b = (k < ones);
                6:       b = (s % 2) == 0;
                default: b = (s < 14) ? d[13-s] : 1'b0;
            endcase
            r[15-j] = b;
        end
        return r;
    endfunction

    function automatic logic [127:0] mdl_bus(int sel, logic tw, logic s16, logic lsb,
                                             logic [13:0] word, logic [13:0] base);
        logic [127:0] e;
        logic [13:0]  d;
        for (int c = 0; c < NCH; c++) begin
            d = (sel == 0) ? base + 14'(c) : word;
            for (int w = 0; w < 2; w++)
                e[(c*2+w)*16 +: 16] = mdl_wire(sel, w, tw, s16, lsb, d);
        end
        return e;
    endfunction

    function automatic string req_of(int sel, logic tw);
        case (sel)
            0:       return "R2";
            1, 2, 7: return "R3";
            4:       return "R5";
            5:       return tw ? "R7" : "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic set_samples(logic [13:0] base);
        for (int c = 0; c < NCH; c++) sample_in[c*14 +: 14] = base + 14'(c);
    endtask

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane(int c, int w);
        return lane_frame[(c*2+w)*16 +: 16];
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", lane_frame, '0);
        check("R1", {127'd0, frame_vld}, '0);
        pat_sel = 3'd1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {127'd0, frame_vld}, 128'd1);

        // table walk (R2 R3 R5 R6 R7 R8)
        for (int v = 0; v < NVEC; v++) begin
            pat_sel   = VEC[v][33:31];
            two_wire  = VEC[v][30];
            ser16     = VEC[v][29];
            lsb_first = VEC[v][28];
            cust_hi   = VEC[v][27:21];
            cust_lo   = VEC[v][20:14];
            set_samples(VEC[v][13:0]);
            repeat (3) @(negedge clk);
            check(req_of(int'(VEC[v][33:31]), VEC[v][30]), lane_frame,
                  mdl_bus(int'(VEC[v][33:31]), VEC[v][30], VEC[v][29], VEC[v][28],
                          {VEC[v][27:21], VEC[v][20:14]}, VEC[v][13:0]));
        end

        // R2: sample reaches frames one edge later
        pat_sel = 3'd0; two_wire = 1'b0; ser16 = 1'b0; lsb_first = 1'b0;
        set_samples(14'h0100);
        repeat (3) @(negedge clk);
        set_samples(14'h2222);
        @(negedge clk);
        check("R2", lane_frame, mdl_bus(0, 1'b0, 1'b0, 1'b0, 14'h0, 14'h2222));

        // R13: old frame kept for one edge, new code visible after two
        pat_sel = 3'd1;
        repeat (3) @(negedge clk);
        pat_sel = 3'd2;
        @(negedge clk);
        check("R13", lane_frame, '0);
        @(negedge clk);
        check("R13", lane_frame, mdl_bus(2, 1'b0, 1'b0, 1'b0, 14'h0, 14'h0));

        // R4: toggle sequence A, B, A, then re-entry starts at A
        pat_sel = 3'd3;
        repeat (2) @(negedge clk);
        check("R4", lane_frame, mdl_bus(4, 1'b0, 1'b0, 1'b0, 14'h2AAA, 14'h0));
        @(negedge clk);
        check("R4", lane_frame, mdl_bus(4, 1'b0, 1'b0, 1'b0, 14'h1555, 14'h0));
        @(negedge clk);
        check("R4", lane_frame, mdl_bus(4, 1'b0, 1'b0, 1'b0, 14'h2AAA, 14'h0));
        @(negedge clk);
        pat_sel = 3'd1;
        repeat (3) @(negedge clk);
        pat_sel = 3'd3;
        repeat (2) @(negedge clk);
        check("R4", lane_frame, mdl_bus(4, 1'b0, 1'b0, 1'b0, 14'h2AAA, 14'h0));

        // R9: 16x custom word padded with two zero bits
        pat_sel = 3'd4; cust_hi = 7'h7F; cust_lo = 7'h7F; ser16 = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", {112'd0, lane(0, 0)}, {112'd0, 16'hFFFC});

        // R10: 2-wire split, halves on each wire; 1-wire leaves wire 1 idle
        cust_hi = 7'h7F; cust_lo = 7'h00; ser16 = 1'b0; two_wire = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", {96'd0, lane(2, 1), lane(2, 0)}, {96'd0, 16'h0000, 16'hFE00});
        two_wire = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", {112'd0, lane(1, 1)}, '0);

        // R11: 11111110000000 sent LSB first
        lsb_first = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", {112'd0, lane(3, 0)}, {112'd0, 16'h01FC});

        // R12: custom identical on every channel
        check("R12", {96'd0, lane(3, 1), lane(3, 0)}, {96'd0, lane(0, 1), lane(0, 0)});

        // R6 / R7 spot values
        lsb_first = 1'b0; pat_sel = 3'd5; ser16 = 1'b1;
        repeat (3) @(negedge clk);
        check("R6", {112'd0, lane(0, 0)}, {112'd0, 16'hFF00});
        two_wire = 1'b1; ser16 = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", {96'd0, lane(1, 1), lane(1, 0)}, {96'd0, 16'hF000, 16'hF000});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule